// File: doc/BRIEF.md
# BCD/Binary Calendar Clock Core

This block keeps wall-clock time and calendar date in seven byte-wide registers. It advances them by one second for each pulse on a once-per-second input. A small byte-wide register port reads and writes the time fields and two status registers. It also reads a clear-on-read interrupt register. Each time field is kept either as packed BCD (tens digit in the high nibble, units digit in the low nibble) or as a plain binary number. A mode bit in status register B selects the encoding.

Carries pass from seconds to minutes, hours, day and month, and then to a two-digit year. Day of month wraps according to month length. February has 29 days in leap years. The two-digit year stands for 1950 to 2049, so every year in the window that divides by four is a leap year. A separate periodic timer, counted in system clock cycles, raises a sticky interrupt while its enable bit is set. Software clears the interrupt by reading status register C.

Top module: `rtc_core`

## Requirements
- R1: Time fields are packed BCD when status B bit 2 is 0 and plain binary when it is 1. Stored bytes are not converted when the bit changes.
- R2: Each tick with the inhibit bit clear advances seconds by one. Seconds wrap 59→0 and carry to minutes. Minutes wrap 59→0 and carry to hours. Hours wrap 23→0 and carry to the day.
- R3: Day of month wraps to 1 after 31 (months 1,3,5,7,8,10,12), after 30 (months 4,6,9,11) and after 28 or 29 for February, and then carries to the month. The year value stands for 1950–1999 when 50–99 and 2000–2049 when 0–49, so February has 29 days exactly when the year value is divisible by 4.
- R4: Day of week (1 = Sunday) advances with each day carry and wraps 7→1. Month wraps 12→1 with a carry to the year, and the year wraps 99→0.
- R5: While status B bit 7 (update inhibit) is 1, ticks leave every time field unchanged.
- R6: Status A bit 7 (update in progress) ignores writes. It inverts on every read of status A, and the read returns the inverted value. Status A bits 6:0 are written directly.
- R7: Synchronous active-low reset sets status A to 0x26 and status B to 0x42, or to 0x46 when `bcd_strap` is low. It sets the time to 00:00:00, weekday 1, day 1, month 1, year 0, and clears `irq`.
- R8: Status B bit 6 enables the periodic timer. `irq` is set PERIOD cycles after the write that turns the enable on, and then every PERIOD cycles. Clearing the bit stops the timer and discards the partial period.
- R9: `irq` stays set until status register C is read. That read clears it in the same cycle that `rdata` is loaded.
- R10: Reads of status C and D return 0x00, and writes to them change no state.
- R11: A write to a time register loads the byte as given. Later ticks count on from the loaded value.
- R12: Address map: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 8 status A, 9 status B, 10 status C, 11 status D. Other addresses read 0x00. `rdata` holds the read result from the clock edge after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bcd_strap | input | 1 | High selects BCD fields at reset, low selects binary |
| sec_pulse | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Sticky periodic interrupt |

## Verification
Every register result is due one clock edge after its strobe. A write or a tick takes effect at the edge on which it is sampled. Read data appears at the edge after `rd_en`. The bench drives all inputs on the falling edge and samples half a cycle after the edge of interest, so each read sees the state that exists after the preceding write or tick. For the periodic interrupt, the bench counts edges from the edge that samples the enable write. It checks that `irq` is still low after PERIOD-1 edges and high after PERIOD edges. It repeats this after a cancel to show that the partial period was discarded.

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int ADDR_W = 4,
  parameter int PERIOD = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bcd_strap,
  input  logic              sec_pulse,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq
);
  localparam int TM_N  = 7;
  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [ADDR_W-1:0] AD_A = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] AD_B = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] AD_C = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] AD_D = ADDR_W'(11);

  function automatic logic [6:0] dec(input logic [7:0] v, input logic bin);
    logic [6:0] t;
    t = {3'b0, v[7:4]};
    return bin ? v[6:0] : t * 7'd10 + {3'b0, v[3:0]};
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] b, input logic bin);
    logic [6:0] t, u;
    t = b / 7'd10;
    u = b % 7'd10;
    return bin ? {1'b0, b} : {t[3:0], u[3:0]};
  endfunction

  function automatic logic [6:0] mdays(input logic [6:0] mo, input logic leap);
    case (mo)
      7'd2:                     return leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
      default:                  return 7'd31;
    endcase
  endfunction

  logic [7:0]       tm_q [TM_N];
  logic [6:0]       a_q;
  logic [7:0]       b_q;
  logic             uip_q;
  logic             irq_q;
  logic [CNT_W-1:0] cnt_q;

  wire bin    = b_q[2];
  wire pie    = b_q[6];
  wire inhib  = b_q[7];
  wire tick   = sec_pulse && !inhib;
  wire wr_tm  = wr_en && (addr < ADDR_W'(TM_N));
  wire wr_b   = wr_en && (addr == AD_B);
  wire rd_a   = rd_en && (addr == AD_A);
  wire rd_c   = rd_en && (addr == AD_C);

  wire [6:0] s  = dec(tm_q[0], bin);
  wire [6:0] m  = dec(tm_q[1], bin);
  wire [6:0] h  = dec(tm_q[2], bin);
  wire [6:0] w  = dec(tm_q[3], bin);
  wire [6:0] d  = dec(tm_q[4], bin);
  wire [6:0] mo = dec(tm_q[5], bin);
  wire [6:0] y  = dec(tm_q[6], bin);

  wire c_s  = s >= 7'd59;
  wire c_m  = c_s && m >= 7'd59;
  wire c_h  = c_m && h >= 7'd23;
  wire c_d  = c_h && d >= mdays(mo, y[1:0] == 2'b00);
  wire c_mo = c_d && mo >= 7'd12;

  logic [7:0] nxt [TM_N];
  assign nxt[0] = enc(c_s ? 7'd0 : s + 7'd1, bin);
  assign nxt[1] = enc(c_s ? (c_m ? 7'd0 : m + 7'd1) : m, bin);
  assign nxt[2] = enc(c_m ? (c_h ? 7'd0 : h + 7'd1) : h, bin);
  assign nxt[3] = enc(c_h ? (w >= 7'd7 ? 7'd1 : w + 7'd1) : w, bin);
  assign nxt[4] = enc(c_h ? (c_d ? 7'd1 : d + 7'd1) : d, bin);
  assign nxt[5] = enc(c_d ? (c_mo ? 7'd1 : mo + 7'd1) : mo, bin);
  assign nxt[6] = enc(c_mo ? (y >= 7'd99 ? 7'd0 : y + 7'd1) : y, bin);

  wire stop  = wr_b && !wdata[6];
  wire start = wr_b && wdata[6] && !pie;
  wire fire  = pie && (cnt_q == CNT_W'(PERIOD - 1)) && !stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tm_q[0] <= 8'h00; tm_q[1] <= 8'h00; tm_q[2] <= 8'h00;
      tm_q[3] <= 8'h01; tm_q[4] <= 8'h01; tm_q[5] <= 8'h01;
      tm_q[6] <= 8'h00;
      a_q    <= 7'h26;
      b_q    <= bcd_strap ? 8'h42 : 8'h46;
      uip_q  <= 1'b0;
      irq_q  <= 1'b0;
      cnt_q  <= '0;
      rdata  <= 8'h00;
    end else begin
      if (tick)
        for (int i = 0; i < TM_N; i++) tm_q[i] <= nxt[i];
      if (wr_tm) tm_q[addr[2:0]] <= wdata;
      if (wr_en && addr == AD_A) a_q <= wdata[6:0];
      if (wr_b) b_q <= wdata;
      if (rd_a) uip_q <= ~uip_q;

      if (stop || start || fire) cnt_q <= '0;
      else if (pie)              cnt_q <= cnt_q + 1'b1;

      if (fire)      irq_q <= 1'b1;
      else if (rd_c) irq_q <= 1'b0;

      if (rd_en) begin
        if (addr < ADDR_W'(TM_N)) rdata <= tm_q[addr[2:0]];
        else if (addr == AD_A)    rdata <= {~uip_q, a_q};
        else if (addr == AD_B)    rdata <= b_q;
        else                      rdata <= 8'h00;
      end
    end
  end

  assign irq = irq_q;

  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && s >= 7'd59 && !wr_tm) |=> (tm_q[0] == 8'h00));
  a_r5_inhibit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (inhib && !wr_en) |=> $stable(tm_q[0]) && $stable(tm_q[4]));
  a_r6_uip_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(uip_q) |-> $past(rd_a));
  a_r8_irq_needs_pie: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(pie));
  a_r9_readc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !fire) |=> !irq_q);
  a_r10_cd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == AD_C || addr == AD_D)) |=> (rdata == 8'h00));
  always_comb a_r8_cnt_range: assert (!rst_n || cnt_q <= CNT_W'(PERIOD - 1));
endmodule

// File: tb/rtc_core_bench.sv
module rtc_core_bench;
  localparam int P = 40;
  logic clk = 0, rst_n = 0, bcd_strap = 1, sec_pulse = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq;
  int checks = 0, errors = 0;

  rtc_core #(.ADDR_W(4), .PERIOD(P)) u_rtc_core (
    .clk, .rst_n, .bcd_strap, .sec_pulse, .wr_en, .rd_en, .addr, .wdata, .rdata, .irq);

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd(a, v); chk(req, v, e);
  endtask

  task automatic tick();
    @(negedge clk); sec_pulse = 1;
    @(negedge clk); sec_pulse = 0;
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, w, d, mo, y);
    wr(0, s); wr(1, mi); wr(2, h); wr(3, w); wr(4, d); wr(5, mo); wr(6, y);
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk); bcd_strap = strap; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset_state();
    do_reset(1);
    chk("R7 irq", {7'b0, irq}, 8'h00);
    expect_reg("R7 sec", 0, 8'h00);
    expect_reg("R7 wday", 3, 8'h01);
    expect_reg("R7 mday", 4, 8'h01);
    expect_reg("R7 month", 5, 8'h01);
    expect_reg("R7 statB bcd", 9, 8'h42);
    expect_reg("R12 unused addr", 7, 8'h00);
  endtask

  task automatic t_uip();
    expect_reg("R6 first A read", 8, 8'hA6);
    expect_reg("R6 second A read", 8, 8'h26);
    wr(8, 8'hD5);
    expect_reg("R6 write ignores uip", 8, 8'hD5);
    wr(8, 8'h26);
    expect_reg("R6 toggle again", 8, 8'h26);
  endtask

  task automatic t_bcd_rollover();
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    tick();
    expect_reg("R2 sec", 0, 8'h00);
    expect_reg("R2 min", 1, 8'h00);
    expect_reg("R2 hour", 2, 8'h00);
    expect_reg("R4 wday wrap", 3, 8'h01);
    expect_reg("R3 mday 31", 4, 8'h01);
    expect_reg("R4 month wrap", 5, 8'h01);
    expect_reg("R4 year wrap", 6, 8'h00);
    set_time(8'h09, 8'h19, 8'h09, 8'h02, 8'h15, 8'h06, 8'h10);
    tick();
    expect_reg("R1 bcd units carry", 0, 8'h10);
    expect_reg("R1 bcd min kept", 1, 8'h19);
  endtask

  task automatic t_leap();
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h00);
    tick();
    expect_reg("R3 year 2000 leap", 4, 8'h29);
    tick(); tick();
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
    tick();
    expect_reg("R3 leap feb29 wrap", 4, 8'h01);
    expect_reg("R3 leap to march", 5, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
    tick();
    expect_reg("R3 nonleap feb28 wrap", 4, 8'h01);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h23);
    tick();
    expect_reg("R3 april 30 wrap", 4, 8'h01);
    expect_reg("R3 april to may", 5, 8'h05);
  endtask

  task automatic t_inhibit_and_load();
    wr(9, 8'hC2);
    wr(0, 8'h10);
    tick(); tick();
    expect_reg("R5 inhibited sec", 0, 8'h10);
    wr(9, 8'h42);
    tick();
    expect_reg("R11 continue from load", 0, 8'h11);
  endtask

  task automatic t_periodic();
    logic [7:0] v;
    wr(9, 8'h02);
    rd(10, v);
    chk("R10 C reads zero", v, 8'h00);
    chk("R9 cleared by C read", {7'b0, irq}, 8'h00);
    repeat (P + 10) @(negedge clk);
    chk("R8 disabled no irq", {7'b0, irq}, 8'h00);
    wr(9, 8'h42);
    repeat (P - 1) @(negedge clk);
    chk("R8 not before period", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R8 at period", {7'b0, irq}, 8'h01);
    repeat (5) @(negedge clk);
    chk("R9 sticky", {7'b0, irq}, 8'h01);
    wr(11, 8'hFF);
    wr(10, 8'hFF);
    chk("R10 writes no effect", {7'b0, irq}, 8'h01);
    expect_reg("R10 D reads zero", 11, 8'h00);
    rd(10, v);
    chk("R9 clear", {7'b0, irq}, 8'h00);
    wr(9, 8'h02);
    wr(9, 8'h42);
    repeat (20) @(negedge clk);
    wr(9, 8'h02);
    wr(9, 8'h42);
    repeat (P - 1) @(negedge clk);
    chk("R8 cancel discards partial", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R8 full period after restart", {7'b0, irq}, 8'h01);
  endtask

  task automatic t_binary();
    do_reset(0);
    expect_reg("R7 statB binary", 9, 8'h46);
    set_time(8'd59, 8'd59, 8'd23, 8'd7, 8'd28, 8'd2, 8'd24);
    tick();
    expect_reg("R1 bin sec", 0, 8'd0);
    expect_reg("R1 bin hour", 2, 8'd0);
    expect_reg("R1 bin leap mday", 4, 8'd29);
    expect_reg("R4 bin wday", 3, 8'd1);
    set_time(8'd59, 8'd59, 8'd23, 8'd1, 8'd30, 8'd9, 8'd49);
    tick();
    expect_reg("R3 bin sep 30", 4, 8'd1);
    expect_reg("R3 bin month", 5, 8'd10);
    wr(0, 8'd37);
    tick();
    expect_reg("R11 bin load", 0, 8'd38);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_uip();
    t_bcd_rollover();
    t_leap();
    t_inhibit_and_load();
    t_periodic();
    t_binary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule